// File: doc/BRIEF.md
# Memory Card SPI Start-Up Sequencer

This block takes a removable memory card from power-up to a ready state in SPI mode and reports which generation of card it found. A pulse on `start` begins the run. The block first clocks out idle bytes with the card deselected. It then moves the card to SPI mode with the reset command and probes the card's voltage and version support. Next it repeats the application-specific initialise command until the card leaves its idle state. Finally it fixes the block length at 512 bytes. At the end it raises a one-cycle `done`, together with a card type and an error flag.

The block does not serialise bits itself. It drives an external byte-wide SPI master through a strobe/done handshake, and it owns the chip select line and a slow/fast clock-rate select. An internal command engine turns each request into a six-byte frame. The engine then polls for the one-byte status reply, collects any trailing reply bytes, and closes the transaction with a deselected filler byte. A sequencing FSM above the engine chooses the commands and interprets the replies.

Top module: `sdspi_init_seq`

## Requirements
- R1: After `start`, WAKE_BYTES bytes of 0xFF are transferred with `spi_cs_n` high before any command byte. `spi_fast` is 0 for every byte of the run.
- R2: Each command is six bytes with chip select low: {2'b01, index[5:0]}, the 32-bit argument most significant byte first, then a check byte. The check byte is 0x87 for index 8 and 0x95 for all other indices. After the reply, the engine transfers exactly one 0xFF byte with `spi_cs_n` high.
- R3: After the frame, the engine clocks 0xFF and accepts the first received byte whose bit 7 is 0 as the status byte, trying at most POLL_LIMIT bytes. If no such byte arrives, the status is taken as 0xFF. For indices 8 and 58 a valid status is followed by four more bytes clocked with chip select low.
- R4: Index 0 (argument 0) is sent first. Any status other than 0x01 ends the run with `error`=1 and `card_type`=0.
- R5: Index 8 is sent next with argument 0x000001AA. Status 0x01 selects the version-2 path and reports `card_type`=2. Status 0x05 selects the version-1 path and reports `card_type`=1. Any other status fails with `card_type`=0.
- R6: Each initialise attempt sends index 55 (argument 0) and then index 41. The index-41 argument is 0 on the version-1 path and 0x40000000 on the version-2 path. A status of 0x00 from index 41 ends the loop.
- R7: On the version-2 path, index 58 (argument 0) is sent before every attempt and once more after success. At least GAP_CYCLES clock cycles separate the previous transaction's last byte from each pre-attempt index-58 frame.
- R8: If ATTEMPT_LIMIT attempts pass with no 0x00 status from index 41, the run fails with `error`=1 and `card_type`=0, and no further command is sent.
- R9: After successful initialisation, index 16 is sent with argument 512. A status of 0x00 completes with `error`=0. Any nonzero status fails with `card_type`=0.
- R10: `spi_fast` goes high only on successful completion. A failed run leaves it low.
- R11: `busy` is high from the cycle after an accepted `start` until `done`. `done` is a one-cycle pulse during which `busy` is low. A `start` while `busy` is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a start-up run (ignored while busy) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Last run failed |
| card_type | output | 2 | 0 fail, 1 version 1, 2 version 2 |
| spi_start | output | 1 | One-cycle strobe for the SPI master to transfer `spi_tx` |
| spi_tx | output | 8 | Byte to send |
| spi_rx | input | 8 | Byte received, valid with `spi_done` |
| spi_done | input | 1 | SPI master finished the byte |
| spi_cs_n | output | 1 | Card chip select, active low |
| spi_fast | output | 1 | 0 slow start-up rate, 1 fast transfer rate |

## Verification
The run result is due on the first falling edge at which `done` is seen. `card_type`, `error` and `spi_fast` are registered in the same cycle as `done`, so the bench samples all four there. `busy` is checked at the falling edge one cycle after the `start` pulse, because the sequencer registers it at the next rising edge. The bench's SPI master model sees each `spi_start` strobe at a falling edge and returns `spi_done` one cycle later. It computes every reply byte and logs every frame with its byte count and start cycle. These logs are compared with sequences and byte totals derived arithmetically from the scenario: the busy-attempt count, the reply delay, and the status values.

// File: rtl/sdi_pkg.sv
package sdi_pkg;

    typedef enum logic [1:0] {
        CARD_FAIL = 2'd0,
        CARD_V1   = 2'd1,
        CARD_V2   = 2'd2
    } card_kind_e;

    typedef enum logic [1:0] {
        EN_IDLE,
        EN_XFER,
        EN_WAIT
    } eng_state_e;

    typedef enum logic [2:0] {
        PH_WAKE,
        PH_CMD,
        PH_POLL,
        PH_EXTRA,
        PH_TAIL
    } eng_phase_e;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_WAKE,
        SQ_RESET,
        SQ_IFCOND,
        SQ_GAP,
        SQ_OCR_PRE,
        SQ_APP,
        SQ_OPCOND,
        SQ_OCR_POST,
        SQ_BLKLEN
    } seq_state_e;

    localparam logic [5:0] IDX_RESET  = 6'd0;
    localparam logic [5:0] IDX_IFCOND = 6'd8;
    localparam logic [5:0] IDX_BLKLEN = 6'd16;
    localparam logic [5:0] IDX_OPCOND = 6'd41;
    localparam logic [5:0] IDX_APP    = 6'd55;
    localparam logic [5:0] IDX_OCR    = 6'd58;

    localparam logic [7:0] CHK_DEFAULT = 8'h95;
    localparam logic [7:0] CHK_IFCOND  = 8'h87;
    localparam logic [7:0] FILL_BYTE   = 8'hFF;
    localparam logic [7:0] ST_IDLE     = 8'h01;
    localparam logic [7:0] ST_IDLE_ILL = 8'h05;
    localparam logic [7:0] ST_READY    = 8'h00;

    localparam logic [31:0] ARG_IFCOND = 32'h0000_01AA;
    localparam logic [31:0] ARG_HCS    = 32'h4000_0000;
    localparam logic [31:0] ARG_BLKLEN = 32'd512;

endpackage

// File: rtl/sdi_cmd_engine.sv
module sdi_cmd_engine
    import sdi_pkg::*;
#(
    parameter int WAKE_BYTES = 16,
    parameter int POLL_LIMIT = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req,
    input  logic        req_wake,
    input  logic [5:0]  req_idx,
    input  logic [31:0] req_arg,
    input  logic [2:0]  req_extra,
    output logic        ack,
    output logic [7:0]  status,
    output logic        spi_start,
    output logic [7:0]  spi_tx,
    input  logic [7:0]  spi_rx,
    input  logic        spi_done,
    output logic        spi_cs_n
);

    localparam int CNT_MAX0 = (WAKE_BYTES > POLL_LIMIT) ? WAKE_BYTES : POLL_LIMIT;
    localparam int CNT_MAX  = (CNT_MAX0 > 7) ? CNT_MAX0 : 7;
    localparam int CW       = $clog2(CNT_MAX + 1);

    typedef struct packed {
        eng_state_e   st;
        eng_phase_e   ph;
        logic [CW-1:0] cnt;
        logic [5:0]   idx;
        logic [31:0]  arg;
        logic [2:0]   extra;
        logic [7:0]   status;
        logic         ack;
    } eng_t;

    eng_t eng_d, eng_q;

    always_comb begin
        eng_d     = eng_q;
        eng_d.ack = 1'b0;
        case (eng_q.st)
            EN_IDLE: begin
                if (req) begin
                    eng_d.st    = EN_XFER;
                    eng_d.cnt   = '0;
                    eng_d.idx   = req_idx;
                    eng_d.arg   = req_arg;
                    eng_d.extra = req_extra;
                    eng_d.ph    = req_wake ? PH_WAKE : PH_CMD;
                end
            end
            EN_XFER: eng_d.st = EN_WAIT;
            EN_WAIT: begin
                if (spi_done) begin
                    eng_d.st = EN_XFER;
                    case (eng_q.ph)
                        PH_WAKE: begin
                            if (eng_q.cnt == CW'(WAKE_BYTES - 1)) begin
                                eng_d.st  = EN_IDLE;
                                eng_d.ack = 1'b1;
                            end else begin
                                eng_d.cnt = eng_q.cnt + CW'(1);
                            end
                        end
                        PH_CMD: begin
                            if (eng_q.cnt == CW'(5)) begin
                                eng_d.ph  = PH_POLL;
                                eng_d.cnt = '0;
                            end else begin
                                eng_d.cnt = eng_q.cnt + CW'(1);
                            end
                        end
                        PH_POLL: begin
                            if (!spi_rx[7]) begin
                                eng_d.status = spi_rx;
                                eng_d.cnt    = '0;
                                eng_d.ph     = (eng_q.extra == 3'd0) ? PH_TAIL : PH_EXTRA;
                            end else if (eng_q.cnt == CW'(POLL_LIMIT - 1)) begin
                                eng_d.status = FILL_BYTE;
                                eng_d.ph     = PH_TAIL;
                            end else begin
                                eng_d.cnt = eng_q.cnt + CW'(1);
                            end
                        end
                        PH_EXTRA: begin
                            if (eng_q.cnt == CW'(eng_q.extra) - CW'(1)) begin
                                eng_d.ph = PH_TAIL;
                            end else begin
                                eng_d.cnt = eng_q.cnt + CW'(1);
                            end
                        end
                        default: begin
                            eng_d.st  = EN_IDLE;
                            eng_d.ack = 1'b1;
                        end
                    endcase
                end
            end
            default: eng_d.st = EN_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q        <= '0;
            eng_q.st     <= EN_IDLE;
            eng_q.ph     <= PH_WAKE;
            eng_q.status <= FILL_BYTE;
        end else begin
            eng_q <= eng_d;
        end
    end

    always_comb begin
        spi_tx = FILL_BYTE;
        if (eng_q.ph == PH_CMD) begin
            case (eng_q.cnt)
                CW'(0):  spi_tx = {2'b01, eng_q.idx};
                CW'(1):  spi_tx = eng_q.arg[31:24];
                CW'(2):  spi_tx = eng_q.arg[23:16];
                CW'(3):  spi_tx = eng_q.arg[15:8];
                CW'(4):  spi_tx = eng_q.arg[7:0];
                default: spi_tx = (eng_q.idx == IDX_IFCOND) ? CHK_IFCOND : CHK_DEFAULT;
            endcase
        end
    end

    assign spi_start = (eng_q.st == EN_XFER);
    assign spi_cs_n  = !((eng_q.st != EN_IDLE) &&
                         ((eng_q.ph == PH_CMD) || (eng_q.ph == PH_POLL) || (eng_q.ph == PH_EXTRA)));
    assign ack       = eng_q.ack;
    assign status    = eng_q.status;

endmodule

// File: rtl/sdi_seq_ctrl.sv
module sdi_seq_ctrl
    import sdi_pkg::*;
#(
    parameter int ATTEMPT_LIMIT = 5000,
    parameter int GAP_CYCLES    = 50000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        eng_ack,
    input  logic [7:0]  eng_status,
    output logic        eng_req,
    output logic        eng_wake,
    output logic [5:0]  eng_idx,
    output logic [31:0] eng_arg,
    output logic [2:0]  eng_extra,
    output logic        busy,
    output logic        done,
    output logic        error,
    output logic [1:0]  card_type,
    output logic        fast
);

    localparam int AW = $clog2(ATTEMPT_LIMIT + 1);
    localparam int GW = $clog2(GAP_CYCLES + 1);

    typedef struct packed {
        seq_state_e   st;
        logic         issued;
        logic         v2;
        logic [AW-1:0] attempts;
        logic [GW-1:0] gap;
        logic         busy;
        logic         done;
        logic         error;
        card_kind_e   kind;
        logic         fast;
    } seq_t;

    seq_t sq_d, sq_q;

    always_comb begin
        sq_d      = sq_q;
        sq_d.done = 1'b0;
        if (sq_q.st == SQ_IDLE) begin
            if (start) begin
                sq_d.st       = SQ_WAKE;
                sq_d.busy     = 1'b1;
                sq_d.error    = 1'b0;
                sq_d.kind     = CARD_FAIL;
                sq_d.fast     = 1'b0;
                sq_d.attempts = '0;
                sq_d.issued   = 1'b0;
                sq_d.v2       = 1'b0;
            end
        end else if (sq_q.st == SQ_GAP) begin
            if (sq_q.gap == GW'(GAP_CYCLES - 1)) begin
                sq_d.st = SQ_OCR_PRE;
            end else begin
                sq_d.gap = sq_q.gap + GW'(1);
            end
        end else if (!sq_q.issued) begin
            sq_d.issued = 1'b1;
        end else if (eng_ack) begin
            sq_d.issued = 1'b0;
            case (sq_q.st)
                SQ_WAKE:  sq_d.st = SQ_RESET;
                SQ_RESET: begin
                    if (eng_status == ST_IDLE) sq_d.st = SQ_IFCOND;
                    else                       sq_d.st = SQ_IDLE;
                end
                SQ_IFCOND: begin
                    if (eng_status == ST_IDLE) begin
                        sq_d.v2  = 1'b1;
                        sq_d.gap = '0;
                        sq_d.st  = SQ_GAP;
                    end else if (eng_status == ST_IDLE_ILL) begin
                        sq_d.st = SQ_APP;
                    end else begin
                        sq_d.st = SQ_IDLE;
                    end
                end
                SQ_OCR_PRE: sq_d.st = SQ_APP;
                SQ_APP:     sq_d.st = SQ_OPCOND;
                SQ_OPCOND: begin
                    if (eng_status == ST_READY) begin
                        sq_d.st = sq_q.v2 ? SQ_OCR_POST : SQ_BLKLEN;
                    end else if (sq_q.attempts == AW'(ATTEMPT_LIMIT - 1)) begin
                        sq_d.st = SQ_IDLE;
                    end else begin
                        sq_d.attempts = sq_q.attempts + AW'(1);
                        sq_d.gap      = '0;
                        sq_d.st       = sq_q.v2 ? SQ_GAP : SQ_APP;
                    end
                end
                SQ_OCR_POST: sq_d.st = SQ_BLKLEN;
                default: begin
                    if (eng_status == ST_READY) begin
                        sq_d.st   = SQ_IDLE;
                        sq_d.busy = 1'b0;
                        sq_d.done = 1'b1;
                        sq_d.fast = 1'b1;
                        sq_d.kind = sq_q.v2 ? CARD_V2 : CARD_V1;
                    end else begin
                        sq_d.st = SQ_IDLE;
                    end
                end
            endcase
            if (sq_d.st == SQ_IDLE && !sq_d.done) begin
                sq_d.busy  = 1'b0;
                sq_d.done  = 1'b1;
                sq_d.error = 1'b1;
                sq_d.kind  = CARD_FAIL;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq_q      <= '0;
            sq_q.st   <= SQ_IDLE;
            sq_q.kind <= CARD_FAIL;
        end else begin
            sq_q <= sq_d;
        end
    end

    always_comb begin
        eng_idx   = IDX_RESET;
        eng_arg   = '0;
        eng_extra = 3'd0;
        case (sq_q.st)
            SQ_IFCOND: begin
                eng_idx   = IDX_IFCOND;
                eng_arg   = ARG_IFCOND;
                eng_extra = 3'd4;
            end
            SQ_OCR_PRE, SQ_OCR_POST: begin
                eng_idx   = IDX_OCR;
                eng_extra = 3'd4;
            end
            SQ_APP: eng_idx = IDX_APP;
            SQ_OPCOND: begin
                eng_idx = IDX_OPCOND;
                eng_arg = sq_q.v2 ? ARG_HCS : 32'd0;
            end
            SQ_BLKLEN: begin
                eng_idx = IDX_BLKLEN;
                eng_arg = ARG_BLKLEN;
            end
            default: ;
        endcase
    end

    assign eng_req   = (sq_q.st != SQ_IDLE) && (sq_q.st != SQ_GAP) && !sq_q.issued;
    assign eng_wake  = (sq_q.st == SQ_WAKE);
    assign busy      = sq_q.busy;
    assign done      = sq_q.done;
    assign error     = sq_q.error;
    assign card_type = sq_q.kind;
    assign fast      = sq_q.fast;

endmodule

// File: rtl/sdspi_init_seq.sv
module sdspi_init_seq #(
    parameter int WAKE_BYTES    = 16,
    parameter int POLL_LIMIT    = 5000,
    parameter int ATTEMPT_LIMIT = 5000,
    parameter int GAP_CYCLES    = 50000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    output logic       busy,
    output logic       done,
    output logic       error,
    output logic [1:0] card_type,
    output logic       spi_start,
    output logic [7:0] spi_tx,
    input  logic [7:0] spi_rx,
    input  logic       spi_done,
    output logic       spi_cs_n,
    output logic       spi_fast
);

    logic        eng_req;
    logic        eng_wake;
    logic [5:0]  eng_idx;
    logic [31:0] eng_arg;
    logic [2:0]  eng_extra;
    logic        eng_ack;
    logic [7:0]  eng_status;

    sdi_seq_ctrl #(
        .ATTEMPT_LIMIT (ATTEMPT_LIMIT),
        .GAP_CYCLES    (GAP_CYCLES)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .eng_ack    (eng_ack),
        .eng_status (eng_status),
        .eng_req    (eng_req),
        .eng_wake   (eng_wake),
        .eng_idx    (eng_idx),
        .eng_arg    (eng_arg),
        .eng_extra  (eng_extra),
        .busy       (busy),
        .done       (done),
        .error      (error),
        .card_type  (card_type),
        .fast       (spi_fast)
    );

    sdi_cmd_engine #(
        .WAKE_BYTES (WAKE_BYTES),
        .POLL_LIMIT (POLL_LIMIT)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (eng_req),
        .req_wake  (eng_wake),
        .req_idx   (eng_idx),
        .req_arg   (eng_arg),
        .req_extra (eng_extra),
        .ack       (eng_ack),
        .status    (eng_status),
        .spi_start (spi_start),
        .spi_tx    (spi_tx),
        .spi_rx    (spi_rx),
        .spi_done  (spi_done),
        .spi_cs_n  (spi_cs_n)
    );

endmodule

// File: rtl/sdspi_init_seq_chk.sv
module sdspi_init_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic       error,
    input logic [1:0] card_type,
    input logic       spi_start,
    input logic       spi_cs_n,
    input logic       spi_fast
);

    // R2: card stays deselected whenever no run is in progress
    assert_cs_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> spi_cs_n);

    // R2: byte strobe lasts a single cycle
    assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        spi_start |=> !spi_start);

    // R11: SPI traffic only during a run
    assert_strobe_in_run_R11: assert property (@(posedge clk) disable iff (!rst_n)
        spi_start |-> busy);

    // R11: an accepted start raises busy next cycle
    assert_start_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R11: done ends a run and is not busy
    assert_done_ends_run_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R4: failures report the fail type
    assert_fail_type_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && error) |-> (card_type == 2'd0));

    // R5: successful runs report version 1 or 2
    assert_ok_type_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !error) |-> (card_type == 2'd1 || card_type == 2'd2));

    // R10: fast rate never during a run, and always after success
    assert_fast_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        spi_fast |-> !busy);

    assert_fast_on_ok_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !error) |-> spi_fast);

endmodule

bind sdspi_init_seq sdspi_init_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .error     (error),
    .card_type (card_type),
    .spi_start (spi_start),
    .spi_cs_n  (spi_cs_n),
    .spi_fast  (spi_fast)
);

// File: tb/sdspi_init_seq_tb.sv
`timescale 1ns/1ps
module sdspi_init_seq_tb;

    localparam int WAKE  = 16;
    localparam int POLL  = 8;
    localparam int LIMIT = 6;
    localparam int GAP   = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       busy, done, error, spi_start, spi_cs_n, spi_fast;
    logic [1:0] card_type;
    logic [7:0] spi_tx;
    logic [7:0] spi_rx = 8'hFF;
    logic       spi_done = 1'b0;

    sdspi_init_seq #(
        .WAKE_BYTES (WAKE),
        .POLL_LIMIT (POLL),
        .ATTEMPT_LIMIT (LIMIT),
        .GAP_CYCLES (GAP)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .start (start), .busy (busy), .done (done),
        .error (error), .card_type (card_type), .spi_start (spi_start),
        .spi_tx (spi_tx), .spi_rx (spi_rx), .spi_done (spi_done),
        .spi_cs_n (spi_cs_n), .spi_fast (spi_fast)
    );

    always #4 clk = ~clk;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // scenario
    logic [7:0] cfg_r0, cfg_r8, cfg_r16;
    int cfg_busy, cfg_delay;
    bit cfg_silent;

    // card model state and logs
    int cmd_pos, resp_idx, cur_extra, attempts_seen;
    logic [7:0] cur_st;
    logic [7:0] fbuf [6];
    bit cmd_seen;
    int wake_ff, cs_high_bytes, cs_high_nonff, fast_bytes, last_byte_cyc;
    int n_cmds;
    int log_idx [64];
    logic [31:0] log_arg [64];
    logic [7:0] log_chk [64];
    bit log_hdr [64];
    int log_bytes [64];
    int log_gap [64];

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] reply_for(input int idx);
        case (idx)
            0:  return cfg_r0;
            8:  return cfg_r8;
            55: return 8'h01;
            41: begin
                attempts_seen++;
                return (attempts_seen > cfg_busy) ? 8'h00 : 8'h01;
            end
            58: return 8'h00;
            16: return cfg_r16;
            default: return 8'h04;
        endcase
    endfunction

    function automatic logic [7:0] card_out(input logic cs);
        if (cs || cfg_silent || cmd_pos < 6) return 8'hFF;
        if (resp_idx < cfg_delay) return 8'hFF;
        if (resp_idx == cfg_delay) return cur_st;
        if (resp_idx <= cfg_delay + cur_extra) return 8'h00;
        return 8'hFF;
    endfunction

    function automatic void card_in(input logic [7:0] tx, input logic cs);
        if (cs) begin
            cs_high_bytes++;
            if (tx != 8'hFF) cs_high_nonff++;
            if (!cmd_seen) wake_ff++;
            cmd_pos = 0;
            resp_idx = 0;
        end else begin
            cmd_seen = 1'b1;
            if (cmd_pos < 6) begin
                if (cmd_pos == 0) log_gap[n_cmds] = cyc - last_byte_cyc;
                fbuf[cmd_pos] = tx;
                cmd_pos++;
                if (cmd_pos == 6) begin
                    log_idx[n_cmds]   = int'(fbuf[0][5:0]);
                    log_hdr[n_cmds]   = (fbuf[0][7:6] == 2'b01);
                    log_arg[n_cmds]   = {fbuf[1], fbuf[2], fbuf[3], fbuf[4]};
                    log_chk[n_cmds]   = fbuf[5];
                    log_bytes[n_cmds] = 6;
                    cur_st    = reply_for(log_idx[n_cmds]);
                    cur_extra = (log_idx[n_cmds] == 8 || log_idx[n_cmds] == 58) ? 4 : 0;
                    n_cmds++;
                end
            end else begin
                resp_idx++;
                log_bytes[n_cmds-1]++;
            end
        end
        last_byte_cyc = cyc;
    endfunction

    // SPI master model: strobe seen at a falling edge, done one cycle later
    initial begin
        bit pend;
        logic [7:0] rx_pend;
        pend = 1'b0;
        rx_pend = 8'hFF;
        forever begin
            @(negedge clk);
            spi_done = 1'b0;
            if (pend) begin
                spi_rx = rx_pend;
                spi_done = 1'b1;
                pend = 1'b0;
            end
            if (spi_start) begin
                if (spi_fast) fast_bytes++;
                rx_pend = card_out(spi_cs_n);
                card_in(spi_tx, spi_cs_n);
                pend = 1'b1;
            end
        end
    end

    task automatic run(input string tag, input logic [7:0] r0, input logic [7:0] r8,
                       input logic [7:0] r16, input int busyn, input int delay,
                       input bit silent, input bit poke);
        int exp_idx [64];
        int exp_n;
        bit v2, ok, tout, init_ok;
        int n_att, k, first_bad, extra_dones;
        int exp_type;
        cfg_r0 = r0; cfg_r8 = r8; cfg_r16 = r16;
        cfg_busy = busyn; cfg_delay = delay; cfg_silent = silent;
        cmd_pos = 0; resp_idx = 0; cur_extra = 0; attempts_seen = 0; cur_st = 8'hFF;
        cmd_seen = 1'b0; wake_ff = 0; cs_high_bytes = 0; cs_high_nonff = 0;
        fast_bytes = 0; n_cmds = 0; last_byte_cyc = cyc;

        // expected command order
        tout = silent || (delay >= POLL);
        exp_n = 0; v2 = 1'b0; ok = 1'b0;
        exp_idx[exp_n++] = 0;
        if (!tout && r0 == 8'h01) begin
            exp_idx[exp_n++] = 8;
            if (r8 == 8'h01 || r8 == 8'h05) begin
                v2 = (r8 == 8'h01);
                init_ok = (busyn < LIMIT);
                n_att = init_ok ? busyn + 1 : LIMIT;
                for (int a = 0; a < n_att; a++) begin
                    if (v2) exp_idx[exp_n++] = 58;
                    exp_idx[exp_n++] = 55;
                    exp_idx[exp_n++] = 41;
                end
                if (init_ok) begin
                    if (v2) exp_idx[exp_n++] = 58;
                    exp_idx[exp_n++] = 16;
                    ok = (r16 == 8'h00);
                end
            end
        end
        exp_type = ok ? (v2 ? 2 : 1) : 0;

        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R11", {tag, " busy after start"}, int'(busy), 1);
        k = 0;
        while (!done && k < 20000) begin
            @(negedge clk);
            k++;
            start = (poke && k == 40 && !done);
        end
        start = 1'b0;
        chk(done == 1'b1, "R11", {tag, " done seen"}, int'(done), 1);
        chk(busy == 1'b0, "R11", {tag, " busy low at done"}, int'(busy), 0);
        chk(int'(card_type) == exp_type, "R5", {tag, " card type"}, int'(card_type), exp_type);
        chk(error == !ok, ok ? "R9" : "R4", {tag, " error flag"}, int'(error), int'(!ok));
        chk(spi_fast == ok, "R10", {tag, " fast select"}, int'(spi_fast), int'(ok));
        chk(fast_bytes == 0, "R1", {tag, " bytes at fast rate"}, fast_bytes, 0);
        chk(wake_ff == WAKE, "R1", {tag, " wake bytes"}, wake_ff, WAKE);
        chk(cs_high_bytes == WAKE + n_cmds && cs_high_nonff == 0, "R2",
            {tag, " deselected bytes"}, cs_high_bytes, WAKE + n_cmds);

        // command order (R6, R7, R8)
        chk(n_cmds == exp_n, v2 ? "R7" : "R8", {tag, " command count"}, n_cmds, exp_n);
        first_bad = -1;
        for (int i = 0; i < exp_n && i < n_cmds; i++)
            if (first_bad < 0 && log_idx[i] != exp_idx[i]) first_bad = i;
        chk(first_bad < 0, "R6", {tag, " command order"},
            (first_bad < 0) ? 0 : log_idx[first_bad], (first_bad < 0) ? 0 : exp_idx[first_bad]);

        // framing, arguments, byte counts, gaps
        first_bad = -1;
        for (int i = 0; i < n_cmds; i++) begin
            logic [31:0] ea;
            logic [7:0] ec;
            ea = 32'd0;
            if (log_idx[i] == 8)  ea = 32'h1AA;
            if (log_idx[i] == 16) ea = 32'd512;
            if (log_idx[i] == 41) ea = v2 ? 32'h4000_0000 : 32'd0;
            ec = (log_idx[i] == 8) ? 8'h87 : 8'h95;
            if (first_bad < 0 && (!log_hdr[i] || log_arg[i] != ea || log_chk[i] != ec)) first_bad = i;
        end
        chk(first_bad < 0, "R2", {tag, " frame fields"}, first_bad, -1);
        first_bad = -1;
        for (int i = 0; i < n_cmds; i++) begin
            int eb;
            eb = tout ? 6 + POLL : 6 + delay + 1 + ((log_idx[i] == 8 || log_idx[i] == 58) ? 4 : 0);
            if (first_bad < 0 && log_bytes[i] != eb) first_bad = i;
        end
        chk(first_bad < 0, "R3", {tag, " selected byte count"},
            (first_bad < 0) ? 0 : log_bytes[first_bad], -1);
        if (v2) begin
            first_bad = -1;
            for (int i = 0; i + 1 < n_cmds; i++)
                if (log_idx[i] == 58 && log_idx[i+1] == 55 && log_gap[i] < GAP && first_bad < 0)
                    first_bad = i;
            chk(first_bad < 0, "R7", {tag, " gap before attempt"},
                (first_bad < 0) ? GAP : log_gap[first_bad], GAP);
        end

        extra_dones = 0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (done || busy) extra_dones++;
        end
        chk(extra_dones == 0, "R11", {tag, " quiet after done"}, extra_dones, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0 && error == 0 && card_type == 2'd0, "R11", "reset outputs",
            int'({busy, done, error, card_type}), 0);
        chk(spi_cs_n == 1 && spi_fast == 0 && spi_start == 0, "R1", "reset SPI lines",
            int'({spi_cs_n, spi_fast, spi_start}), 4);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int b = 0; b <= LIMIT + 1; b++) run($sformatf("v2 busy%0d", b), 8'h01, 8'h01, 8'h00, b, 1, 0, 0);
        for (int b = 0; b <= LIMIT + 1; b++) run($sformatf("v1 busy%0d", b), 8'h01, 8'h05, 8'h00, b, 0, 0, 0);
        for (int d = 0; d <= POLL; d++)     run($sformatf("delay%0d", d), 8'h01, 8'h01, 8'h00, 1, d, 0, 0);
        run("reset 00", 8'h00, 8'h01, 8'h00, 0, 0, 0, 0);
        run("reset 05", 8'h05, 8'h01, 8'h00, 0, 0, 0, 0);
        run("reset 03", 8'h03, 8'h01, 8'h00, 0, 2, 0, 0);
        run("ifc 00",   8'h01, 8'h00, 8'h00, 0, 0, 0, 0);
        run("ifc 04",   8'h01, 8'h04, 8'h00, 0, 0, 0, 0);
        run("ifc 03",   8'h01, 8'h03, 8'h00, 0, 1, 0, 0);
        run("ifc 0d",   8'h01, 8'h0D, 8'h00, 0, 0, 0, 0);
        run("blk v2",   8'h01, 8'h01, 8'h40, 1, 0, 0, 0);
        run("blk v1",   8'h01, 8'h05, 8'h20, 2, 0, 0, 0);
        run("silent",   8'h01, 8'h01, 8'h00, 0, 0, 1, 0);
        run("restart ignored", 8'h01, 8'h01, 8'h00, 2, 1, 0, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait (cyc > 190000);
        total++;
        bad++;
        $display("FAIL R11 watchdog: actual=%0d expected=%0d", cyc, 190000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule